// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the device-side serial port of a converter. A host drives chip select (active low), a serial clock that idles high, and a data input. The block answers on a data output with a separate output-enable for the pad. Every exchange starts with an 8-bit command byte. The command byte picks read or write and one of four register addresses. The addressed register then moves MSB first over the wire. The block holds an 8-bit read-only status word, a 24-bit configuration register, an 8-bit filter register and a 16-bit read-only result register. It also keeps the ready and error flags and the standby and oscillator-off requests. The conversion engine sits outside the block and appears only as a result-valid strobe with a result word, a clamp flag, and a strobe that marks the blanking interval before the next update.

The serial pins are sampled with the system clock, which must run well above the serial clock. Input bits are captured on rising serial-clock edges. Output bits change after falling edges. A long run of ones on the data input returns the whole port to a clean state, so a host that has lost track of the framing can recover.

Top module: `sra_top`

## Requirements
- R1: After reset, rdyN is 1, sdoOe is 0, cfgOut is 0x000000, filtOut is 0x45, and standby and oscPd are 0.
- R2: While the first bit of a command is sampled as 1, the port keeps waiting on that first position. A 0 there makes the next seven bits complete the command byte.
- R3: Command bit 6 selects read (1) or write (0), and bits 1:0 select the address. Every accepted command loads standby from bit 5 and oscPd from bit 4.
- R4: Address 01 moves the 24-bit configuration, address 10 moves the 8-bit filter and address 11 moves the 16-bit result. Address 00 reads 8 status bits. A write command to address 00 has no data phase.
- R5: Read data leaves the port MSB first and changes after falling serial-clock edges. sdoOe is 1 only during the data phase of a read with csN low.
- R6: resultValid loads resultIn and sets the ready flag, and rdyN is its inverse. The flag clears when a full result read completes, or on preUpdate.
- R7: The error flag takes resultClamp when a result loads, and it clears together with the ready flag.
- R8: The status word is {ready, 0, 0, 0, error, 0, standby, pllLock}, bit 7 first. The standby bit shows the value carried by the command that reads it.
- R9: A configuration write appears on cfgOut as soon as its last bit arrives. A filter write takes effect only while standby is set, and is otherwise dropped.
- R10: Raising csN in the middle of a write commits nothing and returns the port to waiting for a command.
- R11: 32 consecutive rising serial-clock edges with sdi high, with csN low, reset all registers and flags to their R1 values. Any sampled 0 restarts this count.
- R12: When the last bit of a register has moved, the port again waits for a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for the sdo pad |
| rdyN | output | 1 | Active-low ready indication |
| resultValid | input | 1 | Strobe: new result available |
| resultIn | input | 16 | Result word from the converter |
| resultClamp | input | 1 | Result was clamped |
| preUpdate | input | 1 | Strobe: blanking before next update |
| pllLock | input | 1 | Clock lock status |
| cfgOut | output | 24 | Current configuration register |
| filtOut | output | 8 | Current filter register |
| standby | output | 1 | Standby request |
| oscPd | output | 1 | Oscillator-off-in-standby request |

## Verification
The assertions assume that sclk and csN come from the system-clock domain already synchronised. They also assume that each serial-clock level lasts several system clocks, so that every edge is seen exactly once. The bench holds each level for four system clocks and changes sdi only while sclk is low. The bench feeds results only between transactions. Random payloads stay below 32 consecutive ones, because every command begins with a 0 and read phases drive sdi low. The long-ones reset is therefore entered only on purpose.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [1:0] {
    S_WEN  = 2'd0,
    S_CMD  = 2'd1,
    S_DATA = 2'd2
  } ifcState_e;

  typedef struct packed {
    logic       cmdLoad;
    logic       cmdStandby;
    logic       cmdOsc;
    logic [1:0] addr;
    logic       loadOut;
    logic       shiftOut;
    logic       shiftIn;
    logic       commit;
    logic       resultRead;
    logic       ifReset;
  } sraStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
#(
  parameter int CFG_W      = 24,
  parameter int FILT_W     = 8,
  parameter int RES_W      = 16,
  parameter int STAT_W     = 8,
  parameter int ONES_LIMIT = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output sraStrobe_t strb,
  output logic       outEn
);

  localparam int SH_W   = maxOf(maxOf(CFG_W, RES_W), maxOf(FILT_W, STAT_W));
  localparam int CNT_W  = $clog2(SH_W) + 1;
  localparam int ONES_W = $clog2(ONES_LIMIT) + 1;
  localparam int CMD_BITS = 7;

  function automatic int lenOf(input logic [1:0] a);
    case (a)
      2'b01:   return CFG_W;
      2'b10:   return FILT_W;
      2'b11:   return RES_W;
      default: return STAT_W;
    endcase
  endfunction

  logic             sclkQ;
  logic             rise, fall;
  ifcState_e        state;
  logic [CNT_W-1:0] bitCnt;
  logic [5:0]       cmdSh;
  logic             readQ;
  logic [1:0]       addrQ;
  logic [ONES_W-1:0] onesCnt;
  logic [6:0]       cmdWord;
  logic             lastCmd, lastData, onesHit;

  assign rise    = !csN && sclk && !sclkQ;
  assign fall    = !csN && !sclk && sclkQ;
  assign cmdWord = {cmdSh, sdi};
  assign lastCmd  = (state == S_CMD) && (int'(bitCnt) == CMD_BITS - 1);
  assign lastData = (state == S_DATA) && (int'(bitCnt) == lenOf(addrQ) - 1);
  assign onesHit  = rise && sdi && (int'(onesCnt) == ONES_LIMIT - 1);

  always_comb begin
    strb            = '0;
    strb.ifReset    = onesHit;
    strb.cmdLoad    = rise && lastCmd && !onesHit;
    strb.cmdStandby = cmdWord[5];
    strb.cmdOsc     = cmdWord[4];
    strb.addr       = lastCmd ? cmdWord[1:0] : addrQ;
    strb.loadOut    = strb.cmdLoad && cmdWord[6];
    strb.shiftOut   = fall && (state == S_DATA) && readQ;
    strb.shiftIn    = rise && (state == S_DATA) && !readQ;
    strb.commit     = rise && lastData && !readQ && !onesHit;
    strb.resultRead = rise && lastData && readQ && (addrQ == 2'b11) && !onesHit;
  end

  assign outEn = !csN && (state == S_DATA) && readQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b1;
    end else begin
      sclkQ <= sclk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_WEN;
      bitCnt  <= '0;
      cmdSh   <= '0;
      readQ   <= 1'b0;
      addrQ   <= 2'b00;
      onesCnt <= '0;
    end else if (csN) begin
      state  <= S_WEN;
      bitCnt <= '0;
    end else if (onesHit) begin
      state   <= S_WEN;
      bitCnt  <= '0;
      onesCnt <= '0;
      readQ   <= 1'b0;
    end else if (rise) begin
      onesCnt <= sdi ? onesCnt + 1'b1 : '0;
      case (state)
        S_WEN: begin
          if (!sdi) begin
            state  <= S_CMD;
            bitCnt <= '0;
          end
        end
        S_CMD: begin
          cmdSh  <= cmdWord[5:0];
          bitCnt <= bitCnt + 1'b1;
          if (lastCmd) begin
            readQ  <= cmdWord[6];
            addrQ  <= cmdWord[1:0];
            bitCnt <= '0;
            state  <= (!cmdWord[6] && cmdWord[1:0] == 2'b00) ? S_WEN : S_DATA;
          end
        end
        S_DATA: begin
          bitCnt <= bitCnt + 1'b1;
          if (lastData) begin
            state  <= S_WEN;
            bitCnt <= '0;
          end
        end
        default: state <= S_WEN;
      endcase
    end
  end

  // R4
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA) |-> (int'(bitCnt) < lenOf(addrQ)));

  // R11
  ones_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ifReset |=> (state == S_WEN));

  // R12
  done_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rise && lastData) |=> (state == S_WEN));

endmodule

// File: rtl/sra_dp.sv
module sra_dp
  import sra_pkg::*;
#(
  parameter int                CFG_W    = 24,
  parameter int                FILT_W   = 8,
  parameter int                RES_W    = 16,
  parameter int                STAT_W   = 8,
  parameter logic [FILT_W-1:0] FILT_RST = 8'h45
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  sraStrobe_t        strb,
  input  logic              sdi,
  input  logic              resultValid,
  input  logic [RES_W-1:0]  resultIn,
  input  logic              resultClamp,
  input  logic              preUpdate,
  input  logic              pllLock,
  output logic              sdo,
  output logic [CFG_W-1:0]  cfg,
  output logic [FILT_W-1:0] filt,
  output logic              standby,
  output logic              oscPd,
  output logic              ready
);

  localparam int SH_W = maxOf(maxOf(CFG_W, RES_W), maxOf(FILT_W, STAT_W));

  logic [SH_W-1:0]   shReg;
  logic [CFG_W-1:0]  cfgReg;
  logic [FILT_W-1:0] filtReg;
  logic [RES_W-1:0]  resReg;
  logic              rdyReg, errReg, stbyReg, oscReg, sdoReg;
  logic              stbyView;
  logic [STAT_W-1:0] statusWord;
  logic [SH_W-1:0]   loadVal;

  assign stbyView   = strb.cmdLoad ? strb.cmdStandby : stbyReg;
  assign statusWord = STAT_W'({rdyReg, 3'b000, errReg, 1'b0, stbyView, pllLock});

  always_comb begin
    case (strb.addr)
      2'b01:   loadVal = SH_W'(cfgReg)     << (SH_W - CFG_W);
      2'b10:   loadVal = SH_W'(filtReg)    << (SH_W - FILT_W);
      2'b11:   loadVal = SH_W'(resReg)     << (SH_W - RES_W);
      default: loadVal = SH_W'(statusWord) << (SH_W - STAT_W);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      sdoReg <= 1'b0;
    end else if (strb.loadOut) begin
      shReg <= loadVal;
    end else if (strb.shiftOut) begin
      sdoReg <= shReg[SH_W-1];
      shReg  <= shReg << 1;
    end else if (strb.shiftIn) begin
      shReg <= {shReg[SH_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      filtReg <= FILT_RST;
      stbyReg <= 1'b0;
      oscReg  <= 1'b0;
    end else if (strb.ifReset) begin
      cfgReg  <= '0;
      filtReg <= FILT_RST;
      stbyReg <= 1'b0;
      oscReg  <= 1'b0;
    end else begin
      if (strb.cmdLoad) begin
        stbyReg <= strb.cmdStandby;
        oscReg  <= strb.cmdOsc;
      end
      if (strb.commit && strb.addr == 2'b01) begin
        cfgReg <= {shReg[CFG_W-2:0], sdi};
      end
      if (strb.commit && strb.addr == 2'b10 && stbyReg) begin
        filtReg <= {shReg[FILT_W-2:0], sdi};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg <= '0;
      rdyReg <= 1'b0;
      errReg <= 1'b0;
    end else if (strb.ifReset) begin
      resReg <= '0;
      rdyReg <= 1'b0;
      errReg <= 1'b0;
    end else if (resultValid) begin
      resReg <= resultIn;
      rdyReg <= 1'b1;
      errReg <= resultClamp;
    end else if (preUpdate || strb.resultRead) begin
      rdyReg <= 1'b0;
      errReg <= 1'b0;
    end
  end

  assign sdo     = sdoReg;
  assign cfg     = cfgReg;
  assign filt    = filtReg;
  assign standby = stbyReg;
  assign oscPd   = oscReg;
  assign ready   = rdyReg;

  // R6
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !strb.ifReset) |=> rdyReg);

  // R7
  err_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    errReg |-> rdyReg);

  // R9
  filt_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(filtReg) && !$past(strb.ifReset)) |-> $past(stbyReg));

  // R10
  cfg_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> $stable(cfgReg));

endmodule

// File: rtl/sra_top.sv
module sra_top
  import sra_pkg::*;
#(
  parameter int CFG_W      = 24,
  parameter int FILT_W     = 8,
  parameter int RES_W      = 16,
  parameter int ONES_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  output logic              rdyN,
  input  logic              resultValid,
  input  logic [RES_W-1:0]  resultIn,
  input  logic              resultClamp,
  input  logic              preUpdate,
  input  logic              pllLock,
  output logic [CFG_W-1:0]  cfgOut,
  output logic [FILT_W-1:0] filtOut,
  output logic              standby,
  output logic              oscPd
);

  localparam int STAT_W = 8;

  sraStrobe_t strb;
  logic       ready;

  sra_ctrl #(
    .CFG_W(CFG_W), .FILT_W(FILT_W), .RES_W(RES_W),
    .STAT_W(STAT_W), .ONES_LIMIT(ONES_LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .strb(strb), .outEn(sdoOe)
  );

  sra_dp #(
    .CFG_W(CFG_W), .FILT_W(FILT_W), .RES_W(RES_W), .STAT_W(STAT_W),
    .FILT_RST(FILT_W'(8'h45))
  ) i_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .strb(strb), .sdi(sdi),
    .resultValid(resultValid), .resultIn(resultIn),
    .resultClamp(resultClamp), .preUpdate(preUpdate), .pllLock(pllLock),
    .sdo(sdo), .cfg(cfgOut), .filt(filtOut), .standby(standby),
    .oscPd(oscPd), .ready(ready)
  );

  assign rdyN = !ready;

endmodule

// File: tb/test_sra_top.sv
module test_sra_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo, sdoOe, rdyN;
  logic        resultValid = 1'b0;
  logic [15:0] resultIn = '0;
  logic        resultClamp = 1'b0;
  logic        preUpdate = 1'b0;
  logic        pllLock = 1'b1;
  logic [23:0] cfgOut;
  logic [7:0]  filtOut;
  logic        standby, oscPd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] expCfg = '0;
  logic [7:0]  expFilt = 8'h45;
  logic [15:0] expRes = '0;
  logic        expRdy = 0, expErr = 0, expStby = 0, expOsc = 0;

  always #2 clk = ~clk;

  sra_top i_sra_top (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .rdyN(rdyN), .resultValid(resultValid),
    .resultIn(resultIn), .resultClamp(resultClamp), .preUpdate(preUpdate),
    .pllLock(pllLock), .cfgOut(cfgOut), .filtOut(filtOut),
    .standby(standby), .oscPd(oscPd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [1:0] a);
    case (a)
      2'b01:   return 24;
      2'b10:   return 8;
      2'b11:   return 16;
      default: return 8;
    endcase
  endfunction

  function automatic logic [7:0] expStatus();
    return {expRdy, 3'b000, expErr, 1'b0, expStby, pllLock};
  endfunction

  task automatic bitOut(input logic b, output logic r, output logic oe);
    @(negedge clk);
    sclk = 1'b0;
    sdi  = b;
    repeat (4) @(negedge clk);
    r  = sdo;
    oe = sdoOe;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic access(input logic [7:0] cmd, input int n, input logic [23:0] wd,
                        output logic [23:0] rd, output logic oeAll);
    logic r, oe;
    rd = '0;
    oeAll = 1'b1;
    @(negedge clk) csN = 1'b0;
    for (int i = 7; i >= 0; i--) bitOut(cmd[i], r, oe);
    for (int i = n - 1; i >= 0; i--) begin
      bitOut(wd[i], r, oe);
      rd = {rd[22:0], r};
      oeAll &= oe;
    end
    @(negedge clk) csN = 1'b1;
    sdi = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] a, input logic stb, output logic [23:0] v);
    logic oe;
    access({2'b01, stb, 1'b0, 2'b00, a}, lenOf(a), 24'h0, v, oe);
    expStby = stb;
    expOsc  = 1'b0;
    chk("R5 sdoOe during read", {31'b0, oe}, 32'd1);
    chk("R5 sdoOe idle", {31'b0, sdoOe}, 32'd0);
    if (a == 2'b11) begin
      expRdy = 1'b0;
      expErr = 1'b0;
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic stb, input logic [23:0] v);
    logic [23:0] dummy;
    logic oe;
    access({2'b00, stb, 1'b0, 2'b00, a}, (a == 2'b00) ? 0 : lenOf(a), v, dummy, oe);
    expStby = stb;
    expOsc  = 1'b0;
    if (a == 2'b01) expCfg = v;
    if (a == 2'b10 && stb) expFilt = v[7:0];
  endtask

  task automatic inject(input logic [15:0] v, input logic clamp);
    @(negedge clk);
    resultValid = 1'b1;
    resultIn    = v;
    resultClamp = clamp;
    @(negedge clk);
    resultValid = 1'b0;
    expRes = v;
    expRdy = 1'b1;
    expErr = clamp;
    @(negedge clk);
  endtask

  task automatic sendOnes(input int n);
    logic r, oe;
    @(negedge clk) csN = 1'b0;
    for (int i = 0; i < n; i++) bitOut(1'b1, r, oe);
  endtask

  initial begin
    logic [23:0] v;
    logic oe;
    void'($urandom(32'd5179));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rdyN", {31'b0, rdyN}, 32'd1);
    chk("R1 sdoOe", {31'b0, sdoOe}, 32'd0);
    chk("R1 cfgOut", {8'b0, cfgOut}, 32'd0);
    chk("R1 filtOut", {24'b0, filtOut}, 32'h45);
    chk("R1 standby", {30'b0, standby, oscPd}, 32'd0);

    // R4 filter default read, R8 status layout
    readReg(2'b10, 1'b0, v);
    chk("R4 filter read", {8'b0, v}, 32'h45);
    readReg(2'b00, 1'b0, v);
    chk("R8 status after reset", {8'b0, v}, {24'b0, expStatus()});

    // R2 leading ones keep the port on the first bit
    writeReg(2'b01, 1'b0, 24'h5A3C96);
    chk("R9 cfg immediate", {8'b0, cfgOut}, {8'b0, expCfg});
    sendOnes(5);
    access(8'h41, 24, 24'h0, v, oe);
    chk("R2 read after leading ones", {8'b0, v}, {8'b0, expCfg});

    // R3 command byte standby and oscillator bits
    writeReg(2'b00, 1'b1, 24'h0);
    chk("R3 standby from command", {31'b0, standby}, 32'd1);
    access(8'h30, 0, 24'h0, v, oe);
    expStby = 1'b1;
    expOsc = 1'b1;
    chk("R3 oscPd from command", {30'b0, standby, oscPd}, 32'd3);
    readReg(2'b00, 1'b1, v);
    chk("R8 status standby bit", {8'b0, v}, {24'b0, expStatus()});

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: begin
          logic [23:0] w = 24'($urandom) & 24'hFFFFFE;
          writeReg(2'b01, 1'($urandom), w);
          chk("R9 cfg written", {8'b0, cfgOut}, {8'b0, expCfg});
          readReg(2'b01, 1'($urandom), v);
          chk("R4 cfg readback MSB first", {8'b0, v}, {8'b0, expCfg});
        end
        1: begin
          logic stb = 1'($urandom);
          writeReg(2'b10, stb, {16'b0, 8'($urandom)});
          chk("R9 filter gated by standby", {24'b0, filtOut}, {24'b0, expFilt});
          readReg(2'b10, stb, v);
          chk("R4 filter readback", {8'b0, v}, {16'b0, expFilt});
        end
        2: begin
          inject(16'($urandom), 1'($urandom));
          chk("R6 rdyN low after result", {31'b0, rdyN}, 32'd0);
          readReg(2'b00, 1'($urandom), v);
          chk("R7 status error and ready", {8'b0, v}, {24'b0, expStatus()});
          readReg(2'b11, 1'b0, v);
          chk("R4 result read", {8'b0, v}, {16'b0, expRes});
          chk("R6 rdyN high after result read", {31'b0, rdyN}, 32'd1);
        end
        default: begin
          readReg(2'b00, 1'($urandom), v);
          chk("R8 status", {8'b0, v}, {24'b0, expStatus()});
        end
      endcase
    end

    // R6 / R7 blanking strobe clears both flags
    inject(16'hFFFF, 1'b1);
    chk("R7 err with clamp", {31'b0, rdyN}, 32'd0);
    @(negedge clk) preUpdate = 1'b1;
    @(negedge clk) preUpdate = 1'b0;
    expRdy = 1'b0;
    expErr = 1'b0;
    chk("R6 preUpdate clears ready", {31'b0, rdyN}, 32'd1);
    readReg(2'b00, 1'b0, v);
    chk("R7 err cleared with ready", {8'b0, v}, {24'b0, expStatus()});

    // R10 abort mid-write
    writeReg(2'b01, 1'b0, 24'hABCDEE);
    begin
      logic r;
      @(negedge clk) csN = 1'b0;
      for (int i = 7; i >= 0; i--) bitOut(8'h01 >> i, r, oe);
      for (int i = 0; i < 10; i++) bitOut(1'b1, r, oe);
      @(negedge clk) csN = 1'b1;
      sdi = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R10 no partial commit", {8'b0, cfgOut}, {8'b0, expCfg});
    readReg(2'b01, 1'b0, v);
    chk("R10 port back to command", {8'b0, v}, {8'b0, expCfg});
    chk("R12 idle after transfer", {31'b0, sdoOe}, 32'd0);

    // R11: 31 ones then a zero keeps state
    sendOnes(31);
    access(8'h41, 24, 24'h0, v, oe);
    chk("R11 31 ones no reset", {8'b0, v}, {8'b0, expCfg});
    writeReg(2'b10, 1'b1, 24'h000012);
    inject(16'h1234, 1'b0);
    sendOnes(32);
    @(negedge clk) csN = 1'b1;
    repeat (4) @(negedge clk);
    expCfg = '0; expFilt = 8'h45; expRdy = 0; expErr = 0; expStby = 0; expOsc = 0;
    chk("R11 cfg reset", {8'b0, cfgOut}, 32'd0);
    chk("R11 filter reset", {24'b0, filtOut}, 32'h45);
    chk("R11 ready reset", {31'b0, rdyN}, 32'd1);
    chk("R11 standby reset", {31'b0, standby}, 32'd0);
    readReg(2'b00, 1'b0, v);
    chk("R11 status after reset", {8'b0, v}, {24'b0, expStatus()});

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule